// File: doc/BRIEF.md
# Fractional clock rate ramp controller

This block turns a fast reference clock into a stream of single-cycle clock-enable pulses for a processor clock domain. The mean pulse rate is the reference rate times fraction / divider, where both are 5-bit values. A phase accumulator spreads the pulses over time, so the enable never fires in bursts larger than the rate calls for.

A sleep request drops the fraction to the minimum of one. A wake request then restores full speed in one of two ways. It can load the programmed target straight away. Or it can climb toward that target by adding a programmable step at a fixed ramp interval, which spares the supply from a sudden jump in load. When the climb lands on the target, a done flag pulses for one cycle. The current fraction and divider are always visible on a packed status word.

Top module: `frac_clk_ramp`

## Requirements
- R1: During and just after reset, the status word reads fraction 1 in bits 4:0 and divider 10 in bits 12:8, with every other bit zero. The enable and the done flag are both low.
- R2: While fraction F and divider D hold steady (F <= D), any 10*D consecutive cycles contain exactly 10*F enable pulses.
- R3: When the fraction equals the divider, the enable is high on every cycle.
- R4: A sleep request sets the fraction to 1 on the next cycle and keeps the divider, from any state. It takes priority over a wake request in the same cycle, so that wake is dropped.
- R5: A wake request from sleep with step enable low loads the divider and a fraction of min(target, divider) in the next cycle. The done flag stays low.
- R6: A wake request from sleep with step enable high loads the divider and step size in the next cycle and leaves the fraction at 1. The fraction then changes only at ramp ticks. The first tick lands 256 cycles after the wake edge, and each later tick 256 cycles after the one before. At each tick the fraction becomes the previous fraction plus the step.
- R7: During a ramp the fraction is clamped to min(target, divider) and never goes above it. The fraction never exceeds the divider.
- R8: At the tick where the ramp reaches its clamped target, the done flag is high for exactly one cycle. This also holds when the target is already 1.
- R9: A wake request is ignored outside sleep, both while ramping and while running. The status word is unchanged and the ramp timing is not restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep_req | input | 1 | Single-cycle request to drop to the minimum fraction |
| wake_req | input | 1 | Single-cycle request to leave sleep |
| tgt_frac | input | 5 | Programmed target fraction (nonzero) |
| div_val | input | 5 | Programmed divider (nonzero) |
| step_size | input | 5 | Increment added at each ramp tick |
| step_en | input | 1 | Selects the stepped ramp on wake-up |
| clk_en | output | 1 | Clock-enable pulse stream |
| ramp_done | output | 1 | One-cycle flag when the ramp reaches its target |
| status | output | 16 | Current fraction in bits 4:0, current divider in bits 12:8 |

## Verification
The hardest states to reach are the ones at exact tick boundaries: the cycle just before a ramp tick, the cycle of the final clamped step with its done pulse, and a sleep request that cuts into a ramp. The bench gets there by counting cycles from the wake edge. It samples one cycle before and one cycle after each 256-cycle tick, and it places an ignored wake pulse in the middle of a ramp to show that the tick timing is not restarted. Rate checks count enable pulses over windows that are whole multiples of the divider, so each count is exact and does not depend on the accumulator's starting phase.

// File: rtl/frac_clk_ramp_pkg.sv
package frac_clk_ramp_pkg;

  typedef enum logic [1:0] {
    ST_SLEEP = 2'd0,
    ST_RAMP  = 2'd1,
    ST_RUN   = 2'd2
  } ramp_state_e;

endpackage

// File: rtl/fcr_tick_gen.sv
module fcr_tick_gen #(
  parameter int unsigned PERIOD = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);

  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (clr) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick = (cnt_q == LAST) && !clr;

  generate
    if (PERIOD > 1) begin : g_chk
      // R6: ticks are isolated single-cycle events
      a_r6_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/fcr_accum.sv
module fcr_accum #(
  parameter int unsigned FW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [FW-1:0] frac,
  input  logic [FW-1:0] div,
  output logic          en
);

  logic [FW-1:0] acc_q;
  logic [FW-1:0] acc_d;
  logic          en_q;
  logic          en_d;
  logic [FW:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, frac};

  always_comb begin
    if (clr) begin
      acc_d = '0;
      en_d  = 1'b0;
    end else if (sum >= {1'b0, div}) begin
      acc_d = FW'(sum - {1'b0, div});
      en_d  = 1'b1;
    end else begin
      acc_d = sum[FW-1:0];
      en_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      en_q  <= 1'b0;
    end else begin
      acc_q <= acc_d;
      en_q  <= en_d;
    end
  end

  assign en = en_q;

  // R2: residue stays below the divider, so a single subtraction suffices
  a_r2_residue_below_div: assert property (@(posedge clk) disable iff (!rst_n)
    (div != '0) |-> (acc_q < div));

  // R3: full-rate fraction yields an enable on the following cycle
  a_r3_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (frac == div && div != '0 && !clr) |=> en);

endmodule

// File: rtl/fcr_ramp_ctrl.sv
module fcr_ramp_ctrl
  import frac_clk_ramp_pkg::*;
#(
  parameter int unsigned FW         = 5,
  parameter int unsigned RST_FRAC   = 1,
  parameter int unsigned RST_DIV    = 10,
  parameter int unsigned RST_STEP   = 6,
  parameter int unsigned SLEEP_FRAC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_req,
  input  logic          wake_req,
  input  logic [FW-1:0] tgt_frac,
  input  logic [FW-1:0] div_val,
  input  logic [FW-1:0] step_size,
  input  logic          step_en,
  input  logic          tick,
  output logic [FW-1:0] cur_frac,
  output logic [FW-1:0] cur_div,
  output logic          ramp_done,
  output logic          wake_go
);

  localparam logic [FW-1:0] FRAC_INIT  = FW'(RST_FRAC);
  localparam logic [FW-1:0] DIV_INIT   = FW'(RST_DIV);
  localparam logic [FW-1:0] STEP_INIT  = FW'(RST_STEP);
  localparam logic [FW-1:0] FRAC_SLEEP = FW'(SLEEP_FRAC);

  ramp_state_e   st_q, st_d;
  logic [FW-1:0] frac_q, frac_d;
  logic [FW-1:0] div_q, div_d;
  logic [FW-1:0] goal_q, goal_d;
  logic [FW-1:0] step_q, step_d;
  logic          done_q, done_d;
  logic [FW-1:0] goal_clamped;
  logic [FW:0]   sum;

  assign goal_clamped = (tgt_frac > div_val) ? div_val : tgt_frac;
  assign sum          = {1'b0, frac_q} + {1'b0, step_q};
  assign wake_go      = (st_q == ST_SLEEP) && wake_req && !sleep_req;

  always_comb begin
    st_d   = st_q;
    frac_d = frac_q;
    div_d  = div_q;
    goal_d = goal_q;
    step_d = step_q;
    done_d = 1'b0;
    if (sleep_req) begin
      st_d   = ST_SLEEP;
      frac_d = FRAC_SLEEP;
    end else if (wake_go) begin
      div_d  = div_val;
      step_d = step_size;
      goal_d = goal_clamped;
      if (step_en) begin
        st_d = ST_RAMP;
      end else begin
        st_d   = ST_RUN;
        frac_d = goal_clamped;
      end
    end else if (st_q == ST_RAMP && tick) begin
      if (sum >= {1'b0, goal_q}) begin
        frac_d = goal_q;
        st_d   = ST_RUN;
        done_d = 1'b1;
      end else begin
        frac_d = sum[FW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_SLEEP;
      frac_q <= FRAC_INIT;
      div_q  <= DIV_INIT;
      goal_q <= FRAC_INIT;
      step_q <= STEP_INIT;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      frac_q <= frac_d;
      div_q  <= div_d;
      goal_q <= goal_d;
      step_q <= step_d;
      done_q <= done_d;
    end
  end

  assign cur_frac  = frac_q;
  assign cur_div   = div_q;
  assign ramp_done = done_q;

  // R4: sleep lands on the minimum fraction next cycle
  a_r4_sleep_floor: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> (frac_q == FRAC_SLEEP && st_q == ST_SLEEP));

  // R4: divider survives a sleep request
  a_r4_sleep_keeps_div: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> $stable(div_q));

  // R6: fraction frozen between ramp ticks
  a_r6_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RAMP && !tick && !sleep_req) |=> $stable(frac_q));

  // R7: fraction never exceeds the divider
  a_r7_frac_within_div: assert property (@(posedge clk) disable iff (!rst_n)
    frac_q <= div_q);

  // R7: ramping never overshoots the clamped goal
  a_r7_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RAMP) |-> (frac_q <= goal_q || frac_q == FRAC_SLEEP));

  // R8: done is a single-cycle pulse at the goal
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  a_r8_done_at_goal: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (frac_q == goal_q && st_q == ST_RUN));

  // R9: wake outside sleep leaves the divider alone
  a_r9_wake_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_SLEEP && !sleep_req) |=> $stable(div_q));

endmodule

// File: rtl/frac_clk_ramp.sv
module frac_clk_ramp #(
  parameter int unsigned FW          = 5,
  parameter int unsigned TICK_PERIOD = 256,
  parameter int unsigned RST_FRAC    = 1,
  parameter int unsigned RST_DIV     = 10,
  parameter int unsigned RST_STEP    = 6,
  parameter int unsigned SLEEP_FRAC  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_req,
  input  logic          wake_req,
  input  logic [FW-1:0] tgt_frac,
  input  logic [FW-1:0] div_val,
  input  logic [FW-1:0] step_size,
  input  logic          step_en,
  output logic          clk_en,
  output logic          ramp_done,
  output logic [15:0]   status
);

  localparam int DIV_LSB = 8;

  logic          rst_meta_q;
  logic          rst_sync_q;
  logic          tick;
  logic          wake_go;
  logic [FW-1:0] cur_frac;
  logic [FW-1:0] cur_div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  fcr_tick_gen #(
    .PERIOD(TICK_PERIOD)
  ) u_tick (
    .clk  (clk),
    .rst_n(rst_sync_q),
    .clr  (wake_go),
    .tick (tick)
  );

  fcr_ramp_ctrl #(
    .FW        (FW),
    .RST_FRAC  (RST_FRAC),
    .RST_DIV   (RST_DIV),
    .RST_STEP  (RST_STEP),
    .SLEEP_FRAC(SLEEP_FRAC)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .sleep_req(sleep_req),
    .wake_req (wake_req),
    .tgt_frac (tgt_frac),
    .div_val  (div_val),
    .step_size(step_size),
    .step_en  (step_en),
    .tick     (tick),
    .cur_frac (cur_frac),
    .cur_div  (cur_div),
    .ramp_done(ramp_done),
    .wake_go  (wake_go)
  );

  fcr_accum #(
    .FW(FW)
  ) u_accum (
    .clk  (clk),
    .rst_n(rst_sync_q),
    .clr  (wake_go),
    .frac (cur_frac),
    .div  (cur_div),
    .en   (clk_en)
  );

  always_comb begin
    status = '0;
    status[FW-1:0]        = cur_frac;
    status[DIV_LSB +: FW] = cur_div;
  end

endmodule

// File: tb/frac_clk_ramp_tb_top.sv
module frac_clk_ramp_tb_top;

  logic       clk;
  logic       rst_n;
  logic       sleep_req;
  logic       wake_req;
  logic [4:0] tgt_frac;
  logic [4:0] div_val;
  logic [4:0] step_size;
  logic       step_en;
  logic       clk_en;
  logic       ramp_done;
  logic [15:0] status;

  int checks = 0;
  int fails  = 0;

  // {target[18:14], divider[13:9], pulses in 10*divider cycles[8:0]}
  localparam int NVEC = 8;
  localparam logic [18:0] VEC [NVEC] = '{
    {5'd1,  5'd10, 9'd10},
    {5'd5,  5'd10, 9'd50},
    {5'd10, 5'd10, 9'd100},
    {5'd3,  5'd7,  9'd30},
    {5'd31, 5'd31, 9'd310},
    {5'd20, 5'd12, 9'd120},
    {5'd7,  5'd16, 9'd70},
    {5'd1,  5'd1,  9'd10}
  };

  frac_clk_ramp dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep_req(sleep_req),
    .wake_req (wake_req),
    .tgt_frac (tgt_frac),
    .div_val  (div_val),
    .step_size(step_size),
    .step_en  (step_en),
    .clk_en   (clk_en),
    .ramp_done(ramp_done),
    .status   (status)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_sleep;
    sleep_req = 1'b1;
    cyc(1);
    sleep_req = 1'b0;
  endtask

  task automatic pulse_wake;
    wake_req = 1'b1;
    cyc(1);
    wake_req = 1'b0;
  endtask

  task automatic count_en(input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (clk_en) c++;
    end
  endtask

  task automatic count_done(input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (ramp_done) c++;
    end
  endtask

  function automatic int fr();
    return int'(status[4:0]);
  endfunction

  function automatic int dv();
    return int'(status[12:8]);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int cnt;
    int tgt;
    int dvs;
    int exp_f;
    rst_n     = 1'b0;
    sleep_req = 1'b0;
    wake_req  = 1'b0;
    tgt_frac  = 5'd0;
    div_val   = 5'd1;
    step_size = 5'd0;
    step_en   = 1'b0;

    // R1: reset state
    cyc(2);
    chk("R1 status word during reset", int'(status), 16'h0A01);
    chk("R1 enable during reset", int'(clk_en), 0);
    chk("R1 done during reset", int'(ramp_done), 0);
    rst_n = 1'b1;
    cyc(3);
    chk("R1 status after release", int'(status), 16'h0A01);

    // R2/R3/R5: table of direct-load rates
    for (int i = 0; i < NVEC; i++) begin
      tgt = int'(VEC[i][18:14]);
      dvs = int'(VEC[i][13:9]);
      exp_f = (tgt > dvs) ? dvs : tgt;
      tgt_frac = VEC[i][18:14];
      div_val  = VEC[i][13:9];
      step_en  = 1'b0;
      pulse_sleep();
      pulse_wake();
      chk("R5 fraction loaded after wake", fr(), exp_f);
      chk("R5 divider loaded after wake", dv(), dvs);
      chk("R5 no done on direct load", int'(ramp_done), 0);
      cyc(2);
      count_en(10 * dvs, cnt);
      if (exp_f == dvs) chk("R3 full-rate pulse count", cnt, int'(VEC[i][8:0]));
      else              chk("R2 pulse count", cnt, int'(VEC[i][8:0]));
    end

    // R6/R7/R8/R9: stepped ramp 1 -> 7 -> 13 -> 19 -> 20
    tgt_frac  = 5'd20;
    div_val   = 5'd24;
    step_size = 5'd6;
    step_en   = 1'b1;
    pulse_sleep();
    pulse_wake();
    chk("R6 divider loaded at ramp start", dv(), 24);
    chk("R6 fraction held at ramp start", fr(), 1);
    cyc(100);
    div_val = 5'd5;
    pulse_wake();
    chk("R9 wake ignored while ramping (div)", dv(), 24);
    chk("R9 wake ignored while ramping (frac)", fr(), 1);
    div_val = 5'd24;
    cyc(154);
    chk("R6 fraction before first tick", fr(), 1);
    cyc(1);
    chk("R6 first step", fr(), 7);
    chk("R8 no done mid ramp", int'(ramp_done), 0);
    cyc(256);
    chk("R6 second step", fr(), 13);
    cyc(256);
    chk("R6 third step", fr(), 19);
    cyc(255);
    chk("R6 hold before final tick", fr(), 19);
    cyc(1);
    chk("R7 clamped at target", fr(), 20);
    chk("R8 done at target", int'(ramp_done), 1);
    cyc(1);
    chk("R8 done lasts one cycle", int'(ramp_done), 0);
    count_done(600, cnt);
    chk("R8 no further done", cnt, 0);
    chk("R7 fraction stays at target", fr(), 20);

    // R9: wake while running
    tgt_frac = 5'd3;
    div_val  = 5'd9;
    pulse_wake();
    chk("R9 wake ignored while running", int'(status), 16'h1814);

    // R4: sleep from running
    pulse_sleep();
    chk("R4 sleep fraction", fr(), 1);
    chk("R4 sleep keeps divider", dv(), 24);

    // R4: sleep cuts into a ramp
    tgt_frac  = 5'd30;
    div_val   = 5'd30;
    step_size = 5'd2;
    step_en   = 1'b1;
    pulse_wake();
    cyc(256);
    chk("R6 ramp step of 2", fr(), 3);
    pulse_sleep();
    chk("R4 sleep aborts ramp (frac)", fr(), 1);
    chk("R4 sleep aborts ramp (div)", dv(), 30);
    count_done(600, cnt);
    chk("R4 aborted ramp gives no done", cnt, 0);
    chk("R4 aborted ramp stays at 1", fr(), 1);

    // R4: sleep and wake together, sleep wins
    div_val   = 5'd12;
    sleep_req = 1'b1;
    wake_req  = 1'b1;
    cyc(1);
    sleep_req = 1'b0;
    wake_req  = 1'b0;
    chk("R4 simultaneous sleep wins (div)", dv(), 30);
    cyc(300);
    chk("R4 simultaneous sleep wins (frac)", fr(), 1);

    // R8: ramp whose target is already the start value
    tgt_frac  = 5'd1;
    div_val   = 5'd8;
    step_size = 5'd4;
    step_en   = 1'b1;
    pulse_wake();
    cyc(255);
    chk("R8 no early done", int'(ramp_done), 0);
    cyc(1);
    chk("R8 done for target of one", int'(ramp_done), 1);
    chk("R7 fraction stays at one", fr(), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule